// File: doc/BRIEF.md
# Digital Loop Filter for an All-Digital Frequency Synthesizer

This block sits between the phase detector (a time-to-digital converter) and the digitally controlled oscillator of an all-digital synthesizer loop. Every reference period the detector presents one signed phase-error sample with a strobe. The filter adds each sample to a running integrator. In parallel, it passes the sample through a proportional branch and scales that branch by a fixed gain of 5. The sum of the two paths is rounded and clipped into a 13-bit signed tuning word for the oscillator.

The proportional branch can be smoothed by a chain of single-pole low-pass sections, y(k) = y(k-1) + (x(k) - y(k-1))·a. Each coefficient a is a power of two, so each section needs only a subtract, an arithmetic shift and an add. A two-bit select picks the branch output after zero, two or four sections. The zero-section choice gives the widest loop bandwidth. The four-section choice gives the strongest suppression of detector quantisation noise. All sections keep running on every sample whatever the select, so a change of select takes effect on the very next sample and loses no history.

Top module: `adpll_loop_filter`

## Requirements
- R1: While rst_n is low at a clock edge, the integrator, every smoothing section and both pipeline registers clear. After that edge tune_out reads 0 and tune_vld reads 0.
- R2: tune_vld is high in exactly the cycle that follows, by two clock edges, a cycle with err_vld high. Each accepted sample produces one single-cycle pulse.
- R3: On each edge with err_vld high, the integrator becomes its previous value plus err_in. When err_vld is low, err_in and pole_sel have no effect on any state, and the next tune word reflects only the accepted samples.
- R4: The integrator saturates at the range -524288 to 524287 (20-bit signed) and never wraps. After it has clipped, samples of the opposite sign move it down from the clip value.
- R5: With pole_sel = 00 the proportional term is the current sample itself, so tune = Int + 5·err_in for values inside the output range.
- R6: With pole_sel = 01 the proportional term is the output of a two-section chain. The chain carries 8 fractional bits. The first section has coefficient 2^-3, the second 2^-4, and each shifted correction is floored (arithmetic shift right).
- R7: With pole_sel = 10 or 11 the proportional term is the output of a four-section chain. The coefficients are 2^-3, 2^-4, 2^-3, 2^-4 in that order, with the same fixed-point rules as R6.
- R8: All four sections update on every accepted sample regardless of pole_sel. After a change of select, the newly chosen output already carries the full sample history.
- R9: The sum Int·256 + 5·P, where P is the proportional term with 8 fractional bits, is rounded to an integer half-away-from-zero.
- R10: The rounded sum saturates to the 13-bit signed range, -4096 to 4095.
- R11: tune_out and the registered filter state keep their values in every cycle where no new result is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| err_vld | input | 1 | Phase-error sample strobe |
| err_in | input | 13 | Signed phase error from the time-to-digital converter |
| pole_sel | input | 2 | Smoothing depth: 00 none, 01 two sections, 1x four sections |
| tune_out | output | 13 | Signed oscillator tuning word |
| tune_vld | output | 1 | High for one cycle when tune_out has been updated |

## Verification
The bound checker watches the timing skeleton on every cycle:
- the reset values;
- the two-edge gap between err_vld and tune_vld;
- tune_out holding between pulses;
- the integrator and the registered proportional term holding while no sample is accepted.

The arithmetic can only be shown by the bench's scenarios, which compare each result against an independent integer model. That arithmetic covers the floored section updates, the half-away-from-zero rounding, the output clipping, the integrator clipping and its recovery, and the carried-over history after a select change.

// File: rtl/adpll_lf_pkg.sv
// Shared definitions for the loop filter: smoothing-depth codes and the
// per-section coefficient shift. Assumes sections alternate between two shifts.
package adpll_lf_pkg;

    typedef enum logic [1:0] {
        POLES_NONE  = 2'b00,
        POLES_TWO   = 2'b01,
        POLES_FOUR  = 2'b10,
        POLES_FOURB = 2'b11
    } pole_sel_e;

    // Coefficient shift of section idx: even sections use sh_a, odd ones sh_b.
    function automatic int stage_shift(input int idx, input int sh_a, input int sh_b);
        return ((idx % 2) == 0) ? sh_a : sh_b;
    endfunction

endpackage

// File: rtl/lf_integrator.sv
// Saturating integrator of the phase error.
// Adds each accepted sample to the accumulator and clips at the signed
// INT_W limits instead of wrapping. Assumes ERR_W < INT_W.
module lf_integrator #(
    parameter int ERR_W = 13,
    parameter int INT_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [ERR_W-1:0] err_in,
    output logic signed [INT_W-1:0] acc_q
);
    localparam int EXT_W = INT_W + 1;
    localparam logic signed [EXT_W-1:0] ACC_MAX = EXT_W'((64'sd1 <<< (INT_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] ACC_MIN = -ACC_MAX - EXT_W'(1);

    logic signed [EXT_W-1:0] sum_w;
    logic signed [INT_W-1:0] acc_nxt;

    // Widened sum and clip to the accumulator range.
    always_comb begin
        sum_w = EXT_W'(acc_q) + EXT_W'(err_in);
        if (sum_w > ACC_MAX)
            acc_nxt = ACC_MAX[INT_W-1:0];
        else if (sum_w < ACC_MIN)
            acc_nxt = ACC_MIN[INT_W-1:0];
        else
            acc_nxt = sum_w[INT_W-1:0];
    end

    // Accumulator register, advanced only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (upd)
            acc_q <= acc_nxt;
    end

endmodule

// File: rtl/lf_iir_stage.sv
// One single-pole low-pass section with a power-of-two coefficient.
// Computes y + ((x - y) >>> SHIFT); the shift floors. Presents the updated
// value combinationally so the next section sees the same sample's result.
// Assumes |x| stays within the Y_W range, so y stays within it too.
module lf_iir_stage #(
    parameter int Y_W   = 22,
    parameter int SHIFT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd,
    input  logic signed [Y_W-1:0] x_in,
    output logic signed [Y_W-1:0] y_next
);
    localparam int D_W = Y_W + 1;

    logic signed [Y_W-1:0] y_q;
    logic signed [D_W-1:0] diff;
    logic signed [D_W-1:0] corr;

    // Correction term and the section's next value.
    always_comb begin
        diff   = D_W'(x_in) - D_W'(y_q);
        corr   = diff >>> SHIFT;
        y_next = y_q + $signed(corr[Y_W-1:0]);
    end

    // Section state, advanced only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_q <= '0;
        else if (upd)
            y_q <= y_next;
    end

endmodule

// File: rtl/lf_combiner.sv
// Output stage: forms acc*2^FRAC_W + GAIN*prop, rounds half away from zero
// to an integer, clips to OUT_W signed and registers the result with its flag.
// Assumes SUM_W holds both terms with margin.
module lf_combiner #(
    parameter int INT_W  = 20,
    parameter int Y_W    = 22,
    parameter int FRAC_W = 8,
    parameter int GAIN   = 5,
    parameter int OUT_W  = 13,
    parameter int SUM_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_in,
    input  logic signed [INT_W-1:0] acc,
    input  logic signed [Y_W-1:0]   prop,
    output logic signed [OUT_W-1:0] tune_out,
    output logic                    tune_vld
);
    localparam logic signed [SUM_W-1:0] GAIN_S  = SUM_W'(GAIN);
    localparam logic signed [SUM_W-1:0] HALF    = SUM_W'(64'sd1 <<< (FRAC_W - 1));
    localparam logic signed [SUM_W-1:0] OUT_MAX = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] OUT_MIN = -OUT_MAX - SUM_W'(1);

    logic signed [SUM_W-1:0] sum_w;
    logic signed [SUM_W-1:0] mag;
    logic signed [SUM_W-1:0] rnd_mag;
    logic signed [SUM_W-1:0] rnd;
    logic signed [OUT_W-1:0] tune_nxt;

    // Weighted sum of the two paths.
    always_comb begin
        sum_w = (SUM_W'(acc) <<< FRAC_W) + (SUM_W'(prop) * GAIN_S);
    end

    // Symmetric rounding on the magnitude, then clip to the output range.
    always_comb begin
        mag     = (sum_w < 0) ? -sum_w : sum_w;
        rnd_mag = (mag + HALF) >>> FRAC_W;
        rnd     = (sum_w < 0) ? -rnd_mag : rnd_mag;
        if (rnd > OUT_MAX)
            tune_nxt = OUT_MAX[OUT_W-1:0];
        else if (rnd < OUT_MIN)
            tune_nxt = OUT_MIN[OUT_W-1:0];
        else
            tune_nxt = rnd[OUT_W-1:0];
    end

    // Output register: a new word only when the pipeline presents one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tune_out <= '0;
            tune_vld <= 1'b0;
        end else begin
            tune_vld <= vld_in;
            if (vld_in)
                tune_out <= tune_nxt;
        end
    end

endmodule

// File: rtl/adpll_loop_filter.sv
// Loop filter top: integrator plus gained proportional path smoothed by a
// selectable chain of single-pole sections. Two-edge latency from sample to
// tuning word. Assumes at most one sample per clock and N_STAGE >= 2.
module adpll_loop_filter
    import adpll_lf_pkg::*;
#(
    parameter int ERR_W   = 13,
    parameter int OUT_W   = 13,
    parameter int INT_W   = 20,
    parameter int FRAC_W  = 8,
    parameter int GAIN    = 5,
    parameter int N_STAGE = 4,
    parameter int SHIFT_A = 3,
    parameter int SHIFT_B = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    err_vld,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic [1:0]              pole_sel,
    output logic signed [OUT_W-1:0] tune_out,
    output logic                    tune_vld
);
    localparam int Y_W    = ERR_W + FRAC_W + 1;
    localparam int GAIN_W = $clog2(GAIN + 1) + 1;
    localparam int A_W    = INT_W + FRAC_W;
    localparam int P_W    = Y_W + GAIN_W;
    localparam int SUM_W  = ((A_W > P_W) ? A_W : P_W) + 2;
    localparam int TWO_IDX = 2;

    logic signed [Y_W-1:0]   chain [0:N_STAGE];
    logic signed [Y_W-1:0]   prop_sel;
    logic signed [Y_W-1:0]   prop_q;
    logic signed [INT_W-1:0] acc_q;
    logic                    vld_q;

    // Sample in fixed point: FRAC_W fractional bits.
    always_comb begin
        chain[0] = {{(Y_W - ERR_W){err_in[ERR_W-1]}}, err_in} <<< FRAC_W;
    end

    lf_integrator #(
        .ERR_W (ERR_W),
        .INT_W (INT_W)
    ) u_int (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (err_vld),
        .err_in (err_in),
        .acc_q  (acc_q)
    );

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        lf_iir_stage #(
            .Y_W   (Y_W),
            .SHIFT (stage_shift(g, SHIFT_A, SHIFT_B))
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (err_vld),
            .x_in   (chain[g]),
            .y_next (chain[g+1])
        );
    end

    // Tap selection by smoothing depth.
    always_comb begin
        case (pole_sel_e'(pole_sel))
            POLES_NONE: prop_sel = chain[0];
            POLES_TWO:  prop_sel = chain[TWO_IDX];
            default:    prop_sel = chain[N_STAGE];
        endcase
    end

    // First pipeline stage: proportional term and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prop_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= err_vld;
            if (err_vld)
                prop_q <= prop_sel;
        end
    end

    lf_combiner #(
        .INT_W  (INT_W),
        .Y_W    (Y_W),
        .FRAC_W (FRAC_W),
        .GAIN   (GAIN),
        .OUT_W  (OUT_W),
        .SUM_W  (SUM_W)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_in   (vld_q),
        .acc      (acc_q),
        .prop     (prop_q),
        .tune_out (tune_out),
        .tune_vld (tune_vld)
    );

endmodule

// File: rtl/lf_checker.sv
// Timing and hold properties of the loop filter, bound into the top.
module lf_checker #(
    parameter int OUT_W = 13,
    parameter int INT_W = 20,
    parameter int Y_W   = 22
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    err_vld,
    input logic signed [OUT_W-1:0] tune_out,
    input logic                    tune_vld,
    input logic signed [INT_W-1:0] acc_q,
    input logic signed [Y_W-1:0]   prop_q
);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (tune_out == '0 && !tune_vld));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (tune_vld == $past(err_vld, 2)));

    assert_int_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> $stable(acc_q));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !tune_vld) |-> $stable(tune_out));

    assert_prop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> $stable(prop_q));

endmodule

bind adpll_loop_filter lf_checker #(
    .OUT_W (OUT_W),
    .INT_W (INT_W),
    .Y_W   (Y_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_vld  (err_vld),
    .tune_out (tune_out),
    .tune_vld (tune_vld),
    .acc_q    (acc_q),
    .prop_q   (prop_q)
);

// File: tb/sim_adpll_loop_filter.sv
module sim_adpll_loop_filter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_vld = 1'b0;
    logic signed [12:0] err_in = '0;
    logic [1:0]        pole_sel = 2'b00;
    logic signed [12:0] tune_out;
    logic              tune_vld;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    started = 1'b0;
    string cur_req = "R1";

    // Reference model state (plain integers).
    longint m_int, m_intq, m_prop, e_tune;
    longint m_y [4];
    bit     m_v1, e_vld;
    longint x_in, stage_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    adpll_loop_filter u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_vld  (err_vld),
        .err_in   (err_in),
        .pole_sel (pole_sel),
        .tune_out (tune_out),
        .tune_vld (tune_vld)
    );

    function automatic longint ref_word(longint acc, longint p);
        longint s, r;
        s = acc * 256 + 5 * p;
        if (s >= 0) r = (s + 128) >>> 8;
        else        r = -((-s + 128) >>> 8);
        if (r > 4095)  r = 4095;
        if (r < -4096) r = -4096;
        return r;
    endfunction

    // Model: output stage first, then the sample stage, once per edge.
    always @(posedge clk) begin
        started = 1'b1;
        cyc++;
        if (!rst_n) begin
            m_int = 0; m_intq = 0; m_prop = 0; e_tune = 0;
            m_v1 = 0; e_vld = 0;
            for (int i = 0; i < 4; i++) m_y[i] = 0;
        end else begin
            e_vld = m_v1;
            if (m_v1) e_tune = ref_word(m_intq, m_prop);
            m_v1 = err_vld;
            if (err_vld) begin
                m_int = m_int + longint'(err_in);
                if (m_int > 524287)  m_int = 524287;
                if (m_int < -524288) m_int = -524288;
                x_in = longint'(err_in) * 256;
                stage_in = x_in;
                for (int i = 0; i < 4; i++) begin
                    m_y[i] = m_y[i] + ((stage_in - m_y[i]) >>> ((i % 2 == 0) ? 3 : 4));
                    stage_in = m_y[i];
                end
                m_intq = m_int;
                if (pole_sel == 2'b00)      m_prop = x_in;
                else if (pole_sel == 2'b01) m_prop = m_y[1];
                else                        m_prop = m_y[3];
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            n_vec++;
            if (tune_vld !== e_vld) begin
                n_bad++;
                $display("FAIL R2 (%s) tune_vld=%0b expected %0b at cycle %0d", cur_req, tune_vld, e_vld, cyc);
            end else if (tune_out !== 13'(e_tune)) begin
                n_bad++;
                $display("FAIL %s tune_out=%0d expected %0d at cycle %0d", cur_req, tune_out, e_tune, cyc);
            end
        end
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic put(input int e, input logic [1:0] ps, input bit v);
        @(negedge clk);
        err_vld  = v;
        err_in   = 13'(e);
        pole_sel = ps;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(0, pole_sel, 1'b0);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0; err_vld = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        do_reset(4);
        idle(3);

        // R5: no smoothing, spaced samples
        cur_req = "R5";
        put(100, 2'b00, 1); idle(2);
        put(-37, 2'b00, 1); idle(3);
        put(1250, 2'b00, 1); idle(2);
        put(-1250, 2'b00, 1);
        put(3, 2'b00, 1); idle(3);

        // R3: stray err_in and pole_sel while strobe low
        cur_req = "R3";
        put(999, 2'b10, 0); put(-777, 2'b01, 0); put(1200, 2'b11, 0);
        put(7, 2'b00, 1); idle(3);

        // R6: two-section step response
        cur_req = "R6";
        do_reset(2);
        for (int i = 0; i < 20; i++) put(200, 2'b01, 1);
        for (int i = 0; i < 20; i++) put(0, 2'b01, 1);
        idle(3);

        // R7: four-section response, both codes
        cur_req = "R7";
        do_reset(2);
        for (int i = 0; i < 30; i++) put(-300, 2'b10, 1);
        for (int i = 0; i < 10; i++) put(45, 2'b11, 1);
        idle(3);

        // R8: history carried across a select change
        cur_req = "R8";
        do_reset(2);
        for (int i = 0; i < 10; i++) put(500, 2'b01, 1);
        for (int i = 0; i < 6; i++) put(-20, 2'b10, 1);
        put(-20, 2'b00, 1);
        idle(3);

        // R9: small and negative fractional sums exercise rounding
        cur_req = "R9";
        do_reset(2);
        put(1, 2'b01, 1);
        for (int i = 0; i < 8; i++) put(-1, 2'b01, 1);
        for (int i = 0; i < 12; i++) put((i % 3) - 1, 2'b10, 1);
        for (int i = 0; i < 8; i++) put(-5 + i, 2'b01, 1);
        idle(3);

        // R10: output clipping both ways
        cur_req = "R10";
        do_reset(2);
        for (int i = 0; i < 10; i++) put(1250, 2'b00, 1);
        for (int i = 0; i < 30; i++) put(-1250, 2'b00, 1);
        idle(3);

        // R4: integrator clips high then returns into view
        cur_req = "R4";
        do_reset(2);
        for (int i = 0; i < 430; i++) put(1250, 2'b00, 1);
        for (int i = 0; i < 419; i++) put(-1250, 2'b00, 1);
        put(0, 2'b00, 1); idle(3);
        // and low side
        for (int i = 0; i < 430; i++) put(-1250, 2'b00, 1);
        for (int i = 0; i < 419; i++) put(1250, 2'b00, 1);
        put(0, 2'b00, 1); idle(3);

        // R1 again: mid-run reset clears all state
        cur_req = "R1";
        for (int i = 0; i < 5; i++) put(800, 2'b10, 1);
        do_reset(2);
        put(10, 2'b00, 1); idle(3);
        put(10, 2'b10, 1); idle(3);

        // R11: long gap with outputs held
        cur_req = "R11";
        put(-64, 2'b01, 1); idle(8);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule